// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Snapshot Read

This block keeps wall-clock time and date as packed BCD bytes: seconds, minutes, hours, day of month, month, two-digit year and weekday. A single-cycle tick strobe, nominally one per second, advances the count. The count carries from seconds up through the year, and the day carry takes account of month length and leap years.

A host reaches the block through a byte-wide register port: an address, write data, a write enable and combinational read data. A control register holds the run enable, the hour format select and a snapshot request. To set the time, the host stops the counter, writes the time bytes and starts it again. Reads of the time offsets never see live counters. They return shadow bytes that are loaded only when the host asks, so a multi-byte read is always coherent.

Four registered one-cycle event pulses (second, minute, hour, day) come out for downstream interrupt logic.

Top module: `bcd_timekeeper`

## Requirements
- R1: After reset the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x00. The control register reads 0x00 (stopped, 24-hour), the status register reads 0x00 and all event outputs are low.
- R2: Register map: offsets 0x0 to 0x6 are seconds, minutes, hours, day, month, year and weekday, all packed BCD. Offset 0x8 is control: bit 0 is run, bit 3 is 12-hour mode, bit 6 is snapshot request, and the other bits read 0. Offset 0x9 is status. Offset 0x7 and offsets above 0x9 read 0x00.
- R3: A tick advances the time only while control bit 0 is 1. While it is 0, ticks are ignored. Status bit 1 reads 1 exactly when control bit 0 is 1, and the other status bits read 0.
- R4: A write to a time offset replaces that counter byte only while the counter is stopped. While it runs, such writes are ignored.
- R5: Reads of offsets 0x0 to 0x6 return shadow bytes. Writing control with bit 6 set copies all seven live bytes into the shadow at the following clock edge. At no other time do the shadow bytes change.
- R6: The snapshot request bit clears itself at the edge that performs the copy, and reads back 0 afterwards.
- R7: Seconds and minutes roll from 0x59 to 0x00, each carrying into the next field. In 24-hour mode, hours roll from 0x23 to 0x00 with a carry into the day.
- R8: The day rolls to 0x01 after day 0x31, 0x30 (months 4, 6, 9, 11), 0x29 (month 2 when the year is divisible by 4) or 0x28 (other month 2), carrying into the month. Month rolls 0x12 to 0x01 carrying into the year, and year rolls 0x99 to 0x00. Weekday advances once per day carry and rolls 0x06 to 0x00.
- R9: Each event output is high for one cycle, the cycle after the edge that applied the tick. The second event fires on every applied tick, the minute event on a seconds wrap, the hour event on a minutes wrap, and the day event on a day carry.
- R10: With control bit 3 set, the hour byte holds 0x01 to 0x12 in bits 4:0, with bit 7 set for PM. 11 advances to 12 and toggles PM, and 12 advances to 01 without touching PM. Passing 11 PM to 12 AM carries into the day.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle advance strobe |
| addr | input | 4 | Register offset |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write enable |
| rdData | output | 8 | Combinational read data |
| evtSec | output | 1 | Second event pulse |
| evtMin | output | 1 | Minute event pulse |
| evtHour | output | 1 | Hour event pulse |
| evtDay | output | 1 | Day event pulse |

## Verification
The assertions assume the host loads only legal BCD values: month 0x01 to 0x12, and an hour byte that fits the selected format. They also assume the host rewrites the hour byte whenever it changes the format. The bench respects these assumptions: it loads only calendar-valid values, always while the counter is stopped, and it reloads the hour byte after switching to 12-hour mode. Ticks are driven as isolated single-cycle pulses, never while a write is in progress.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int FIELD_W    = $clog2(NUM_FIELDS);

  typedef enum logic [FIELD_W-1:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DAY  = 3'd3,
    F_MON  = 3'd4,
    F_YEAR = 3'd5,
    F_WDAY = 3'd6
  } fieldT;

  // strobes from control to datapath
  typedef struct packed {
    logic               advance;
    logic               load;
    logic [FIELD_W-1:0] loadSel;
    logic [7:0]         loadData;
    logic               snap;
    logic               mode12;
  } calStrobeT;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // year divisible by 4, year in packed BCD
  function automatic logic bcdLeap(input logic [7:0] y);
    logic r;
    if (y[4] == 1'b0) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else              r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction

  function automatic logic [7:0] monthEnd(input logic [7:0] m, input logic [7:0] y);
    logic [7:0] r;
    case (m)
      8'h02:                      r = bcdLeap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bcd_cal_ctrl.sv
module bcd_cal_ctrl
  import bcd_cal_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter logic [3:0] CTRL_ADDR = 4'h8,
  parameter logic [3:0] STAT_ADDR = 4'h9
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              tick,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [7:0]                        wrData,
  input  logic                              wrEn,
  input  logic [NUM_FIELDS-1:0][7:0]        shadow,
  output logic [7:0]                        rdData,
  output calStrobeT                         stb
);

  localparam logic [7:0] CTRL_MASK = 8'h49;
  localparam int RUN_BIT  = 0;
  localparam int MODE_BIT = 3;
  localparam int SNAP_BIT = 6;

  logic [7:0] ctrlR;
  logic       ctrlWr;
  logic       timeHit;

  assign ctrlWr  = wrEn && (addr == ADDR_W'(CTRL_ADDR));
  assign timeHit = (addr < ADDR_W'(NUM_FIELDS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlR <= 8'h00;
    end else if (ctrlWr) begin
      ctrlR <= wrData & CTRL_MASK;
    end else begin
      ctrlR[SNAP_BIT] <= 1'b0;
    end
  end

  always_comb begin
    stb          = '0;
    stb.advance  = tick && ctrlR[RUN_BIT];
    stb.load     = wrEn && timeHit && !ctrlR[RUN_BIT];
    stb.loadSel  = addr[FIELD_W-1:0];
    stb.loadData = wrData;
    stb.snap     = ctrlR[SNAP_BIT];
    stb.mode12   = ctrlR[MODE_BIT];
  end

  always_comb begin
    if (timeHit)                          rdData = shadow[addr[FIELD_W-1:0]];
    else if (addr == ADDR_W'(CTRL_ADDR))  rdData = ctrlR;
    else if (addr == ADDR_W'(STAT_ADDR))  rdData = {6'd0, ctrlR[RUN_BIT], 1'b0};
    else                                  rdData = 8'h00;
  end

  AST_SNAP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlR[SNAP_BIT] && !ctrlWr) |=> !ctrlR[SNAP_BIT]); // R6
  AST_NO_LOAD_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    ctrlR[RUN_BIT] |-> !stb.load); // R4
  AST_NO_ADVANCE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlR[RUN_BIT] |-> !stb.advance); // R3

endmodule

// File: rtl/bcd_cal_datapath.sv
module bcd_cal_datapath
  import bcd_cal_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  calStrobeT                  stb,
  output logic [NUM_FIELDS-1:0][7:0] shadow,
  output logic                       evtSec,
  output logic                       evtMin,
  output logic                       evtHour,
  output logic                       evtDay
);

  localparam logic [NUM_FIELDS-1:0][7:0] RESET_TIME =
    {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NUM_FIELDS-1:0][7:0] liveR;
  logic [NUM_FIELDS-1:0][7:0] liveN;
  logic [NUM_FIELDS-1:0][7:0] shadowR;
  logic minStep, hourStep, dayStep, monStep, yearStep;
  logic [7:0] hrInc;

  always_comb begin
    liveN    = liveR;
    minStep  = 1'b0;
    hourStep = 1'b0;
    dayStep  = 1'b0;
    monStep  = 1'b0;
    yearStep = 1'b0;
    hrInc    = bcdInc({1'b0, liveR[F_HOUR][6:0]});
    if (stb.advance) begin
      minStep     = (liveR[F_SEC] == 8'h59);
      liveN[F_SEC] = minStep ? 8'h00 : bcdInc(liveR[F_SEC]);
      if (minStep) begin
        hourStep     = (liveR[F_MIN] == 8'h59);
        liveN[F_MIN] = hourStep ? 8'h00 : bcdInc(liveR[F_MIN]);
      end
      if (hourStep) begin
        if (stb.mode12) begin
          if (liveR[F_HOUR][6:0] == 7'h11) begin
            liveN[F_HOUR] = {~liveR[F_HOUR][7], 7'h12};
            dayStep       = liveR[F_HOUR][7];
          end else if (liveR[F_HOUR][6:0] == 7'h12) begin
            liveN[F_HOUR] = {liveR[F_HOUR][7], 7'h01};
          end else begin
            liveN[F_HOUR] = {liveR[F_HOUR][7], hrInc[6:0]};
          end
        end else begin
          dayStep       = (liveR[F_HOUR] == 8'h23);
          liveN[F_HOUR] = dayStep ? 8'h00 : bcdInc(liveR[F_HOUR]);
        end
      end
      if (dayStep) begin
        liveN[F_WDAY] = (liveR[F_WDAY] == 8'h06) ? 8'h00 : bcdInc(liveR[F_WDAY]);
        monStep       = (liveR[F_DAY] == monthEnd(liveR[F_MON], liveR[F_YEAR]));
        liveN[F_DAY]  = monStep ? 8'h01 : bcdInc(liveR[F_DAY]);
      end
      if (monStep) begin
        yearStep     = (liveR[F_MON] == 8'h12);
        liveN[F_MON] = yearStep ? 8'h01 : bcdInc(liveR[F_MON]);
      end
      if (yearStep) begin
        liveN[F_YEAR] = (liveR[F_YEAR] == 8'h99) ? 8'h00 : bcdInc(liveR[F_YEAR]);
      end
    end else if (stb.load) begin
      liveN[stb.loadSel] = stb.loadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveR   <= RESET_TIME;
      evtSec  <= 1'b0;
      evtMin  <= 1'b0;
      evtHour <= 1'b0;
      evtDay  <= 1'b0;
    end else begin
      liveR   <= liveN;
      evtSec  <= stb.advance;
      evtMin  <= minStep;
      evtHour <= hourStep;
      evtDay  <= dayStep;
    end
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gShadow
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         shadowR[g] <= RESET_TIME[g];
      else if (stb.snap) shadowR[g] <= liveR[g];
    end
  end

  assign shadow = shadowR;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.load) |=> $stable(liveR)); // R3
  AST_SHADOW_ONLY_ON_SNAP: assert property (@(posedge clk) disable iff (!rstN)
    !stb.snap |=> $stable(shadowR)); // R5
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && liveR[F_SEC] == 8'h59) |=> (liveR[F_SEC] == 8'h00 && evtMin)); // R7
  AST_EVT_MIN_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    evtMin |-> evtSec); // R9
  AST_EVT_HOUR_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    evtHour |-> evtMin); // R9
  AST_EVT_DAY_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    evtDay |-> evtHour); // R9
  AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> (liveR[F_MON] >= 8'h01 && liveR[F_MON] <= 8'h12)); // R8

endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import bcd_cal_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter logic [3:0] CTRL_ADDR = 4'h8,
  parameter logic [3:0] STAT_ADDR = 4'h9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              wrEn,
  output logic [7:0]        rdData,
  output logic              evtSec,
  output logic              evtMin,
  output logic              evtHour,
  output logic              evtDay
);

  calStrobeT                  stb;
  logic [NUM_FIELDS-1:0][7:0] shadow;

  bcd_cal_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .shadow(shadow), .rdData(rdData), .stb(stb)
  );

  bcd_cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .shadow(shadow),
    .evtSec(evtSec), .evtMin(evtMin), .evtHour(evtHour), .evtDay(evtDay)
  );

endmodule

// File: tb/bcd_timekeeper_bench.sv
module bcd_timekeeper_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] CTRL = 4'h8;
  localparam logic [3:0] STAT = 4'h9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic wrEn = 1'b0;
  logic [7:0] rdData;
  logic evtSec, evtMin, evtHour, evtDay;

  int nTests = 0;
  int nFail  = 0;
  logic [7:0] ctrlCur = 8'h00;
  logic [3:0] evtSeen;

  // binary reference model
  int mSec, mMin, mHour, mDay, mMon, mYear, mWday;

  bcd_timekeeper u_bcd_timekeeper (
    .clk(clk), .rstN(rstN), .tick(tick), .addr(addr), .wrData(wrData),
    .wrEn(wrEn), .rdData(rdData), .evtSec(evtSec), .evtMin(evtMin),
    .evtHour(evtHour), .evtDay(evtDay)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int daysIn(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic modelTick();
    mSec++;
    if (mSec == 60) begin mSec = 0; mMin++; end
    if (mMin == 60) begin mMin = 0; mHour++; end
    if (mHour == 24) begin
      mHour = 0; mWday = (mWday + 1) % 7; mDay++;
      if (mDay > daysIn(mMon, mYear)) begin
        mDay = 1; mMon++;
        if (mMon == 13) begin mMon = 1; mYear = (mYear + 1) % 100; end
      end
    end
  endtask

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic setCtrl(input logic [7:0] v);
    ctrlCur = v;
    writeReg(CTRL, v);
  endtask

  task automatic snapshot();
    writeReg(CTRL, ctrlCur | 8'h40);
    @(negedge clk);
  endtask

  task automatic doTick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    evtSeen = {evtDay, evtHour, evtMin, evtSec};
    tick = 1'b0;
  endtask

  task automatic loadTime(input int s, input int mi, input int h, input int d,
                          input int mo, input int y, input int w);
    writeReg(4'h0, toBcd(s));  writeReg(4'h1, toBcd(mi));
    writeReg(4'h2, toBcd(h));  writeReg(4'h3, toBcd(d));
    writeReg(4'h4, toBcd(mo)); writeReg(4'h5, toBcd(y));
    writeReg(4'h6, toBcd(w));
    mSec = s; mMin = mi; mHour = h; mDay = d; mMon = mo; mYear = y; mWday = w;
  endtask

  task automatic compareModel(input string tag);
    logic [7:0] v;
    logic [7:0] exp [7];
    exp[0] = toBcd(mSec); exp[1] = toBcd(mMin); exp[2] = toBcd(mHour);
    exp[3] = toBcd(mDay); exp[4] = toBcd(mMon); exp[5] = toBcd(mYear);
    exp[6] = toBcd(mWday);
    snapshot();
    for (int i = 0; i < 7; i++) begin
      readReg(4'(i), v);
      check(v == exp[i], tag, v, exp[i]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired actual=00 expected=01");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check({evtDay, evtHour, evtMin, evtSec} == 4'h0, "R1 events", 8'(evtSec), 8'h00);
    readReg(CTRL, v); check(v == 8'h00, "R1 ctrl", v, 8'h00);
    readReg(STAT, v); check(v == 8'h00, "R1 status", v, 8'h00);
    mSec = 0; mMin = 0; mHour = 0; mDay = 1; mMon = 1; mYear = 0; mWday = 0;
    compareModel("R1 reset time");

    // R2 unmapped offsets and ctrl readback mask
    readReg(4'h7, v); check(v == 8'h00, "R2 offset7", v, 8'h00);
    readReg(4'hC, v); check(v == 8'h00, "R2 offsetC", v, 8'h00);
    setCtrl(8'hB6);
    readReg(CTRL, v); check(v == 8'h00, "R2 ctrl mask", v, 8'h00);
    ctrlCur = 8'h00;

    // R3 stopped counter ignores ticks
    for (int i = 0; i < 3; i++) doTick();
    check(evtSeen == 4'h0, "R3 no event when stopped", 8'(evtSeen), 8'h00);
    compareModel("R3 stopped");

    // R3 status mirrors run
    setCtrl(8'h01);
    readReg(STAT, v); check(v == 8'h02, "R3 status running", v, 8'h02);
    readReg(CTRL, v); check(v == 8'h01, "R2 ctrl readback", v, 8'h01);

    // R4 write while running is ignored
    writeReg(4'h0, 8'h33);
    compareModel("R4 write ignored");

    // R5/R6 shadow holds until next snapshot
    doTick(); modelTick();
    check(evtSeen == 4'h1, "R9 sec event", 8'(evtSeen), 8'h01);
    readReg(4'h0, v); check(v == 8'h00, "R5 shadow held", v, 8'h00);
    writeReg(CTRL, ctrlCur | 8'h40);
    readReg(CTRL, v); check(v == 8'h01, "R6 snap bit cleared", v, 8'h01);
    readReg(4'h0, v); check(v == 8'h01, "R5 shadow updated", v, 8'h01);

    // R7/R8/R9 continuous run across hour, day and leap February
    setCtrl(8'h00);
    loadTime(50, 59, 23, 28, 2, 24, 6);
    setCtrl(8'h01);
    for (int i = 0; i < 14; i++) begin
      logic [3:0] expEvt;
      expEvt = 4'h1;
      if (mSec == 59) expEvt[1] = 1'b1;
      if (mSec == 59 && mMin == 59) expEvt[2] = 1'b1;
      if (mSec == 59 && mMin == 59 && mHour == 23) expEvt[3] = 1'b1;
      doTick(); modelTick();
      check(evtSeen == expEvt, "R9 event pattern", 8'(evtSeen), 8'(expEvt));
      compareModel("R7 run sweep");
    end
    @(negedge clk);
    check({evtDay, evtHour, evtMin, evtSec} == 4'h0, "R9 single cycle", 8'({evtDay, evtHour, evtMin, evtSec}), 8'h00);

    // R8 month-end sweep for a common, a leap and a wrapping year
    for (int yi = 0; yi < 3; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int y;
        y = (yi == 0) ? 23 : (yi == 1) ? 24 : 99;
        setCtrl(8'h00);
        loadTime(59, 59, 23, daysIn(m, y), m, y, m % 7);
        setCtrl(8'h01);
        doTick(); modelTick();
        check(evtSeen == 4'hF, "R8 all events at rollover", 8'(evtSeen), 8'h0F);
        compareModel("R8 month end");
      end
    end

    // R8 non-last day of February in a common year does not roll
    setCtrl(8'h00);
    loadTime(59, 59, 23, 27, 2, 23, 6);
    setCtrl(8'h01);
    doTick(); modelTick();
    compareModel("R8 feb 28 common");

    // R10 12-hour mode
    setCtrl(8'h08);
    loadTime(59, 59, 11, 5, 3, 23, 2);
    setCtrl(8'h09);
    doTick();
    check(evtSeen == 4'h7, "R10 no day event at noon", 8'(evtSeen), 8'h07);
    snapshot();
    readReg(4'h2, v); check(v == 8'h92, "R10 11am to 12pm", v, 8'h92);
    readReg(4'h3, v); check(v == 8'h05, "R10 day kept", v, 8'h05);
    setCtrl(8'h08);
    writeReg(4'h2, 8'h91);
    writeReg(4'h1, 8'h59); writeReg(4'h0, 8'h59);
    setCtrl(8'h09);
    doTick();
    check(evtSeen == 4'hF, "R10 day event at midnight", 8'(evtSeen), 8'h0F);
    snapshot();
    readReg(4'h2, v); check(v == 8'h12, "R10 11pm to 12am", v, 8'h12);
    readReg(4'h3, v); check(v == 8'h06, "R10 day advanced", v, 8'h06);
    readReg(4'h6, v); check(v == 8'h03, "R8 weekday advanced", v, 8'h03);
    setCtrl(8'h08);
    writeReg(4'h1, 8'h59); writeReg(4'h0, 8'h59);
    setCtrl(8'h09);
    doTick();
    snapshot();
    readReg(4'h2, v); check(v == 8'h01, "R10 12 to 01", v, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule